// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block decides which of a serial port's five interrupt causes is reported to software, and drives the single interrupt request line. It holds the interrupt enable register, the sticky overrun and break flags, the transmitter-empty pending flag and the modem line change flags. The receive path supplies the remaining state as plain inputs: data ready, the FIFO fill count and trigger threshold, the character timeout flag and the per-character parity and framing errors.

A host register port with separate read and write strobes reaches four registers: the enable register, the identification register, the line status register and the modem status register. Reading some of these registers clears the conditions that they report. The identification value and the request line are combinational functions of the stored state and the live inputs, so they change in the same cycle as the inputs. All stored state changes on the clock edge that samples a strobe or an event.

Top module: `uart_irq_ident`

## Requirements
- R1: The identification code is taken from the highest-priority active source. The codes, from highest to lowest priority, are: line status 0x6, character timeout 0xC, receive data 0x4, transmitter empty 0x2, modem change 0x0. When no source is active the code is 0x1. The code is the low nibble of `iid`.
- R2: A line status request is active when enable bit 2 is set and any of overrun, parity error, framing error or break is set.
- R3: The character timeout request has no enable of its own. It is gated by enable bit 0, the same bit that gates receive data.
- R4: When `fifo_en` is 1, receive data is requested only if `data_rdy` is 1 and `rx_cnt` >= `rx_trig`. When `fifo_en` is 0, `data_rdy` alone requests it.
- R5: Bits 7:6 of `iid` are 11 when `fifo_en` is 1 and 00 when it is 0. Bits 5:4 are always 0.
- R6: A read of the identification register (select 2) clears the transmitter-empty pending flag, but only when that read reports code 0x2. A read that reports any other code leaves the flag set. The flag is gated by enable bit 1.
- R7: A write to the enable register (select 1) stores only data bits 3:0, and a read returns 0 in bits 7:4. If `thr_empty` is 1 during the write, the write also sets the transmitter-empty pending flag.
- R8: The line status register (select 5) reads {00, thr_empty, break, frm_err, par_err, overrun, data_rdy}, most significant bit first. A read of it clears break and overrun. Parity and framing errors follow their inputs.
- R9: The modem status register (select 6) reads {sampled lines[3:0], change flags[3:0]}. A change flag is set when its line differs from the previous sample, except flag 2, which is set only when line 2 falls from 1 to 0. A read of this register clears all four change flags. A modem request is active when enable bit 3 is set and any change flag is set.
- R10: `irq` is 1 exactly when the code is not 0x1.
- R11: An event that sets overrun, break, a change flag or the transmitter-empty pending flag takes priority over a read that would clear that flag in the same cycle.
- R12: A `thre_evt` pulse sets the transmitter-empty pending flag, and a `thr_load` pulse clears it.
- R13: After reset the enable register is 0, every stored flag is 0, the code is 0x1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects occur on this edge |
| reg_sel | input | 3 | Register select: 1 enable, 2 identification, 5 line status, 6 modem status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| fifo_en | input | 1 | FIFO mode active |
| rx_cnt | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger threshold |
| data_rdy | input | 1 | Receive data present |
| tmo_pend | input | 1 | Character timeout pending |
| ovr_evt | input | 1 | Overrun event pulse |
| brk_evt | input | 1 | Break received pulse |
| par_err | input | 1 | Parity error of the head character |
| frm_err | input | 1 | Framing error of the head character |
| thr_empty | input | 1 | Transmit holding register empty |
| thre_evt | input | 1 | Transmitter drained pulse |
| thr_load | input | 1 | Transmit holding register written pulse |
| modem_in | input | 4 | Modem input lines |
| iid | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request |

## Verification
The case most likely to hide a fault is a clearing read that lands in the same cycle as an event setting the flag that the read clears. Three such pairs exist: a line status read with an overrun or break pulse, a modem status read with a line change, and an identification read reporting 0x2 with a drain pulse. The bench aims directed cycles at each pair, and random traffic also produces them. Each result is judged by comparing the next cycle's register reads and request line against a bench model in which the setting event wins.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    // register select values on the host port
    localparam logic [2:0] SEL_IER = 3'd1;
    localparam logic [2:0] SEL_IID = 3'd2;
    localparam logic [2:0] SEL_LSR = 3'd5;
    localparam logic [2:0] SEL_MSR = 3'd6;

    // enable register bit positions
    localparam int IE_RXDATA = 0;
    localparam int IE_THRE   = 1;
    localparam int IE_LINE   = 2;
    localparam int IE_MODEM  = 3;

    localparam int NUM_SRC = 5;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_THRE    = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_code_e;

    typedef struct packed {
        logic oe;
        logic bi;
    } lsr_sticky_t;

    typedef struct packed {
        logic [3:0] ier;
        logic       thre_pend;
    } ctl_state_t;

    // request index 0 is the highest priority
    function automatic iid_code_e src_code(input int idx);
        case (idx)
            0:       return IID_LINE;
            1:       return IID_TIMEOUT;
            2:       return IID_RXDATA;
            3:       return IID_THRE;
            default: return IID_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/iid_line_status.sv
module iid_line_status
    import uart_iid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_evt,
    input  logic brk_evt,
    input  logic rd_clr,
    output logic oe,
    output logic bi
);

    lsr_sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr) begin
            st_d.oe = 1'b0;
            st_d.bi = 1'b0;
        end
        // a new event outranks the clearing read
        if (ovr_evt) st_d.oe = 1'b1;
        if (brk_evt) st_d.bi = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe = st_q.oe;
    assign bi = st_q.bi;

    // R11
    brk_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> bi);

    // R8
    ovr_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ovr_evt) |=> !oe);

endmodule

// File: rtl/iid_modem_delta.sv
module iid_modem_delta #(
    parameter int NLINES    = 4,
    parameter int TRAIL_IDX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines_in,
    input  logic              rd_clr,
    output logic [NLINES-1:0] line_q,
    output logic [NLINES-1:0] dlt_q
);

    typedef struct packed {
        logic [NLINES-1:0] lines;
        logic [NLINES-1:0] dlt;
    } md_state_t;

    md_state_t st_d, st_q;
    logic [NLINES-1:0] hit;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        if (i == TRAIL_IDX) begin : g_trail
            assign hit[i] = st_q.lines[i] & ~lines_in[i];
        end else begin : g_edge
            assign hit[i] = st_q.lines[i] ^ lines_in[i];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.lines = lines_in;
        st_d.dlt   = (rd_clr ? '0 : st_q.dlt) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_q = st_q.lines;
    assign dlt_q  = st_q.dlt;

    // R9
    dlt_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (lines_in == line_q)) |=> (dlt_q == '0));

endmodule

// File: rtl/iid_arbiter.sv
module iid_arbiter
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ier,
    input  logic             err_any,
    input  logic             tmo_pend,
    input  logic             data_rdy,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             thre_pend,
    input  logic             delta_any,
    output iid_code_e        code
);

    logic [NUM_SRC-1:0] req;
    logic               rx_level_ok;

    assign rx_level_ok = !fifo_en || (rx_cnt >= rx_trig);

    always_comb begin
        req[0] = ier[IE_LINE]   & err_any;
        req[1] = ier[IE_RXDATA] & tmo_pend;
        req[2] = ier[IE_RXDATA] & data_rdy & rx_level_ok;
        req[3] = ier[IE_THRE]   & thre_pend;
        req[4] = ier[IE_MODEM]  & delta_any;
    end

    // scan from lowest to highest priority so the highest one remains
    always_comb begin
        code = IID_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) code = src_code(i);
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             data_rdy,
    input  logic             tmo_pend,
    input  logic             ovr_evt,
    input  logic             brk_evt,
    input  logic             par_err,
    input  logic             frm_err,
    input  logic             thr_empty,
    input  logic             thre_evt,
    input  logic             thr_load,
    input  logic [3:0]       modem_in,
    output logic [7:0]       iid,
    output logic             irq
);

    localparam int NLINES = 4;

    ctl_state_t ctl_d, ctl_q;
    iid_code_e  code;
    logic       oe, bi, err_any;
    logic [NLINES-1:0] line_q, dlt_q;
    logic       rd_iid, rd_lsr, rd_msr, wr_ier;
    logic       thre_set, thre_clr;
    logic [3:0] wdata_unused;

    assign wdata_unused = reg_wdata[7:4];

    assign rd_iid = reg_rd && (reg_sel == SEL_IID);
    assign rd_lsr = reg_rd && (reg_sel == SEL_LSR);
    assign rd_msr = reg_rd && (reg_sel == SEL_MSR);
    assign wr_ier = reg_wr && (reg_sel == SEL_IER);

    iid_line_status i_lsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovr_evt (ovr_evt),
        .brk_evt (brk_evt),
        .rd_clr  (rd_lsr),
        .oe      (oe),
        .bi      (bi)
    );

    iid_modem_delta #(.NLINES(NLINES), .TRAIL_IDX(2)) i_msr (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (modem_in),
        .rd_clr   (rd_msr),
        .line_q   (line_q),
        .dlt_q    (dlt_q)
    );

    assign err_any = oe | par_err | frm_err | bi;

    iid_arbiter #(.CNT_W(CNT_W)) i_arb (
        .ier       (ctl_q.ier),
        .err_any   (err_any),
        .tmo_pend  (tmo_pend),
        .data_rdy  (data_rdy),
        .fifo_en   (fifo_en),
        .rx_cnt    (rx_cnt),
        .rx_trig   (rx_trig),
        .thre_pend (ctl_q.thre_pend),
        .delta_any (|dlt_q),
        .code      (code)
    );

    assign iid = {fifo_en, fifo_en, 2'b00, code};
    assign irq = (code != IID_NONE);

    assign thre_set = thre_evt || (wr_ier && thr_empty);
    assign thre_clr = thr_load || (rd_iid && (code == IID_THRE));

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ier) ctl_d.ier = reg_wdata[3:0];
        if (thre_set)      ctl_d.thre_pend = 1'b1;
        else if (thre_clr) ctl_d.thre_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_IER: reg_rdata = {4'b0000, ctl_q.ier};
            SEL_IID: reg_rdata = iid;
            SEL_LSR: reg_rdata = {2'b00, thr_empty, bi, frm_err, par_err, oe, data_rdy};
            SEL_MSR: reg_rdata = {line_q, dlt_q};
            default: reg_rdata = 8'h00;
        endcase
    end

    // R6
    thre_iid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iid && (code == IID_THRE) && !thre_set) |=> !ctl_q.thre_pend);

    // R10
    masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ier == 4'h0) |-> !irq);

    // R7
    ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ier |=> (ctl_q.ier == $past(reg_wdata[3:0])));

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr, reg_rd;
    logic [2:0] reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic fifo_en;
    logic [CNT_W-1:0] rx_cnt, rx_trig;
    logic data_rdy, tmo_pend, ovr_evt, brk_evt, par_err, frm_err;
    logic thr_empty, thre_evt, thr_load;
    logic [3:0] modem_in;
    logic [7:0] iid;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model state
    logic [3:0] m_ier, m_prev, m_dlt;
    logic m_oe, m_bi, m_tp;

    always #10 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_en(fifo_en), .rx_cnt(rx_cnt), .rx_trig(rx_trig),
        .data_rdy(data_rdy), .tmo_pend(tmo_pend), .ovr_evt(ovr_evt),
        .brk_evt(brk_evt), .par_err(par_err), .frm_err(frm_err),
        .thr_empty(thr_empty), .thre_evt(thre_evt), .thr_load(thr_load),
        .modem_in(modem_in), .iid(iid), .irq(irq)
    );

    function automatic logic [3:0] f_code();
        logic ls, ct, rd, th, ms;
        ls = m_ier[2] & (m_oe | par_err | frm_err | m_bi);
        ct = m_ier[0] & tmo_pend;
        rd = m_ier[0] & data_rdy & (!fifo_en || (rx_cnt >= rx_trig));
        th = m_ier[1] & m_tp;
        ms = m_ier[3] & (|m_dlt);
        if (ls) return 4'h6;
        if (ct) return 4'hC;
        if (rd) return 4'h4;
        if (th) return 4'h2;
        if (ms) return 4'h0;
        return 4'h1;
    endfunction

    function automatic logic [7:0] f_rdata(input logic [3:0] cd);
        case (reg_sel)
            3'd1: return {4'h0, m_ier};
            3'd2: return {fifo_en, fifo_en, 2'b00, cd};
            3'd5: return {2'b00, thr_empty, m_bi, frm_err, par_err, m_oe, data_rdy};
            3'd6: return {m_prev, m_dlt};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0; reg_sel = 3'd0; reg_wdata = 8'h00;
        ovr_evt = 0; brk_evt = 0; thre_evt = 0; thr_load = 0;
    endtask

    // check current outputs, then advance one clock and the model with it
    task automatic step(input string lbl);
        logic [3:0] cd, hit, n_dlt, n_ier;
        logic n_oe, n_bi, n_tp, rd_i, rd_l, rd_m, wr_e;
        #1;
        cd = f_code();
        chk(lbl, "iid", iid, {fifo_en, fifo_en, 2'b00, cd});
        chk("R10", "irq", {7'b0, irq}, {7'b0, cd != 4'h1});
        chk(lbl, "rdata", reg_rdata, f_rdata(cd));
        rd_i = reg_rd && reg_sel == 3'd2;
        rd_l = reg_rd && reg_sel == 3'd5;
        rd_m = reg_rd && reg_sel == 3'd6;
        wr_e = reg_wr && reg_sel == 3'd1;
        n_ier = wr_e ? reg_wdata[3:0] : m_ier;
        n_oe = ovr_evt ? 1'b1 : (rd_l ? 1'b0 : m_oe);
        n_bi = brk_evt ? 1'b1 : (rd_l ? 1'b0 : m_bi);
        hit = m_prev ^ modem_in;
        hit[2] = m_prev[2] & ~modem_in[2];
        n_dlt = (rd_m ? 4'h0 : m_dlt) | hit;
        if (thre_evt || (wr_e && thr_empty)) n_tp = 1'b1;
        else if (thr_load || (rd_i && cd == 4'h2)) n_tp = 1'b0;
        else n_tp = m_tp;
        @(posedge clk);
        m_ier = n_ier; m_oe = n_oe; m_bi = n_bi; m_dlt = n_dlt;
        m_prev = modem_in; m_tp = n_tp;
        @(negedge clk);
    endtask

    task automatic wr_ier(input logic [7:0] v, input string lbl);
        reg_wr = 1; reg_sel = 3'd1; reg_wdata = v;
        step(lbl);
        idle();
    endtask

    task automatic rd_reg(input logic [2:0] s, input string lbl);
        reg_rd = 1; reg_sel = s;
        step(lbl);
        idle();
    endtask

    initial begin
        void'($urandom(32'd4711));
        idle();
        fifo_en = 0; rx_cnt = '0; rx_trig = 5'd1; data_rdy = 0; tmo_pend = 0;
        par_err = 0; frm_err = 0; thr_empty = 0; modem_in = 4'h0;
        m_ier = 0; m_prev = 0; m_dlt = 0; m_oe = 0; m_bi = 0; m_tp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        rd_reg(3'd2, "R13");
        rd_reg(3'd1, "R13");
        rd_reg(3'd6, "R13");

        // R2 line status from sticky overrun and from a parity level
        wr_ier(8'h04, "R2");
        ovr_evt = 1; step("R2"); idle();
        step("R2");
        rd_reg(3'd5, "R8");
        step("R8");
        par_err = 1; step("R2"); par_err = 0;
        frm_err = 1; rd_reg(3'd5, "R8"); frm_err = 0;

        // R3 timeout needs enable bit 0
        wr_ier(8'h00, "R3");
        tmo_pend = 1; step("R3");
        wr_ier(8'h01, "R3");
        step("R3");
        data_rdy = 1; step("R1");
        ovr_evt = 1; step("R1"); idle();
        wr_ier(8'h05, "R1"); step("R1");
        rd_reg(3'd5, "R8"); tmo_pend = 0;
        wr_ier(8'h01, "R4");

        // R4 trigger threshold in FIFO mode, R5 upper bits
        fifo_en = 1; rx_trig = 5'd8; rx_cnt = 5'd7; step("R4");
        rx_cnt = 5'd8; step("R4");
        rx_cnt = 5'd14; rx_trig = 5'd14; step("R5");
        fifo_en = 0; rx_cnt = 5'd0; step("R5");
        data_rdy = 0; step("R4");

        // R7 upper bits dropped, pending set by write while empty
        thr_empty = 1;
        wr_ier(8'hF2, "R7");
        rd_reg(3'd1, "R7");
        // R6 IIR read reporting THRE clears it
        rd_reg(3'd2, "R6");
        step("R6");
        // R12 drain pulse sets, load pulse clears
        thr_empty = 0;
        thre_evt = 1; step("R12"); idle();
        step("R12");
        thr_load = 1; step("R12"); idle();
        step("R12");
        // R6 read reporting another code leaves pending
        thre_evt = 1; step("R6"); idle();
        wr_ier(8'h03, "R6");
        data_rdy = 1; rd_reg(3'd2, "R6");
        data_rdy = 0; step("R6");
        rd_reg(3'd2, "R6");
        // R11 drain pulse with clearing IIR read
        thre_evt = 1; step("R11"); idle();
        reg_rd = 1; reg_sel = 3'd2; thre_evt = 1; step("R11"); idle();
        step("R11");

        // R9 trailing edge and change flags
        wr_ier(8'h08, "R9");
        thr_load = 1; step("R9"); idle();
        modem_in = 4'h4; step("R9");
        rd_reg(3'd6, "R9");
        modem_in = 4'h0; step("R9");
        rd_reg(3'd6, "R9");
        modem_in = 4'h1; step("R9");
        rd_reg(3'd6, "R9");
        step("R9");
        // R11 line change with a clearing MSR read; overrun with LSR read
        modem_in = 4'h3; reg_rd = 1; reg_sel = 3'd6; step("R11"); idle();
        rd_reg(3'd6, "R11");
        reg_rd = 1; reg_sel = 3'd5; ovr_evt = 1; brk_evt = 1; step("R11"); idle();
        rd_reg(3'd5, "R11");
        rd_reg(3'd5, "R8");

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            logic [2:0] sels [6];
            sels = '{3'd1, 3'd2, 3'd5, 3'd6, 3'd0, 3'd3};
            idle();
            reg_sel = sels[$urandom % 6];
            reg_rd = ($urandom % 3) == 0;
            reg_wr = !reg_rd && ($urandom % 6) == 0;
            reg_wdata = 8'($urandom);
            if (($urandom % 64) == 0) fifo_en = ~fifo_en;
            case ($urandom % 4)
                0: rx_trig = 5'd1;
                1: rx_trig = 5'd4;
                2: rx_trig = 5'd8;
                default: rx_trig = 5'd14;
            endcase
            rx_cnt = 5'($urandom % 17);
            data_rdy = ($urandom % 2) == 0;
            tmo_pend = ($urandom % 8) == 0;
            ovr_evt = ($urandom % 10) == 0;
            brk_evt = ($urandom % 12) == 0;
            par_err = ($urandom % 10) == 0;
            frm_err = ($urandom % 10) == 0;
            thr_empty = ($urandom % 2) == 0;
            thre_evt = ($urandom % 6) == 0;
            thr_load = ($urandom % 6) == 0;
            if (($urandom % 8) == 0) modem_in = 4'($urandom);
            case (reg_sel)
                3'd1: step("R7");
                3'd2: step("R1");
                3'd5: step("R8");
                3'd6: step("R9");
                default: step("R1");
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule